// File: doc/BRIEF.md
# Infrared SIR pulse encoder and decoder

This block sits between a UART's serial bit stream and an infrared transceiver. On the transmit side each low data bit becomes one short light pulse, and high bits send nothing. On the receive side each qualified pulse from the transceiver is stretched back into a low bit one bit period long. Framing (start, stop, parity) belongs to the UART and is out of scope here. Timing comes from two single-cycle enables: `tick16`, at sixteen times the bit rate, and `lp_tick`, a fixed low-power reference.

The encoder is a four-state machine: IDLE (line high, nothing sent), ARM (low-power pulse waiting for the next reference tick), MARK (pulse driven) and SPACE (rest of the bit period). Its transitions are:
- IDLE to MARK or ARM on a `tick16` with the line low.
- ARM to MARK on `lp_tick`.
- MARK to SPACE once the pulse length is counted.
- Any busy state to MARK or ARM at the bit boundary if the next bit is low, otherwise to IDLE.
- Any state to IDLE when SIR is inactive.

The decoder is a three-state machine after a synchroniser: IDLE, QUAL (pulse seen and waiting for a `tick16`) and LOW (stretched output). Its transitions are:
- IDLE to QUAL on a pulse.
- IDLE to LOW on a pulse that arrives with a tick.
- QUAL back to IDLE if the pulse ends before a tick, or QUAL to LOW if it is still present at a tick.
- LOW reloaded at its last tick when a further pulse is present or was seen, otherwise LOW to IDLE.

A routing stage selects between the SIR paths and the plain UART line and applies the two loopback modes.

Top module: `sir_codec`

## Requirements
- R1: With SIR active and low-power mode off, the encoder starts a pulse at the first `tick16` that samples `uart_txd_in` low. `sir_tx` is 1 from the next clock for exactly 3 `tick16` intervals. Each later low bit gives one more such pulse, 16 ticks after the previous bit start.
- R2: With low-power mode on, a low bit's pulse begins at the first `lp_tick` after the bit start. It lasts exactly 3 `lp_tick` intervals, whatever the `tick16` rate.
- R3: High data bits produce no pulse, and `sir_tx` rests at 0.
- R4: SIR is active only when `cfg_uart_en` and `cfg_sir_en` are both 1. While SIR is inactive the following hold:
  - `sir_tx` is 0 from the next clock.
  - `sir_rx_n` has no effect.
  - `txd` equals `uart_txd_in`.
  - Without plain loopback, `uart_rxd` equals `rxd_in`.
- R5: While SIR is active, `txd` is held at 1 and `rxd_in` has no effect on `uart_rxd`.
- R6: With `cfg_uart_en` at 0, setting `cfg_sir_en` changes nothing: no pulse is produced and `txd` follows `uart_txd_in`.
- R7: With SIR active and both `cfg_loop` and `cfg_sir_test` at 1, the decoder input is the inverse of `sir_tx` and the external `sir_rx_n` is ignored. As a result, `uart_rxd` reproduces the transmitted bits at bit centres.
- R8: With SIR inactive, `cfg_loop` at 1 and `cfg_sir_test` at 0, `uart_rxd` equals `uart_txd_in` and `rxd_in` is ignored.
- R9: `sir_rx_n` is active low. A pulse that is still low, after the 2-stage synchroniser, at a `tick16` drives `uart_rxd` low from the next clock for exactly 16 `tick16` intervals.
- R10: A pulse that has ended, after the synchroniser, before the next `tick16` leaves `uart_rxd` high.
- R11: After reset `sir_tx` is 0 and, with SIR active and no pulses, `uart_rxd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| lp_tick | input | 1 | One-cycle low-power reference enable |
| uart_txd_in | input | 1 | Serial bit stream from the UART transmitter |
| rxd_in | input | 1 | Plain serial receive line |
| sir_rx_n | input | 1 | Infrared receive input, pulse is low |
| cfg_uart_en | input | 1 | UART enable |
| cfg_sir_en | input | 1 | SIR path enable |
| cfg_lowpwr | input | 1 | Low-power pulse width select |
| cfg_loop | input | 1 | Loopback enable |
| cfg_sir_test | input | 1 | Selects SIR-side loopback |
| sir_tx | output | 1 | Infrared output, 1 = light pulse |
| uart_rxd | output | 1 | Serial stream to the UART receiver |
| txd | output | 1 | Plain serial transmit line |

## Verification
A stuck or mis-counting encoder state shows at `sir_tx` within one bit period: a missing, doubled or wrongly sized pulse, measured in clocks against the tick rate. Decoder faults show at `uart_rxd` within about one tick after a pulse is accepted or rejected. A wrong stretch length shows when the low run ends 16 ticks later. Routing errors show at once, in the same cycle, on `txd` or `uart_rxd`. The bench drives random line values in every routing mode and compares these outputs against values computed from the requirements.

// File: rtl/sir_pkg.sv
package sir_pkg;

    typedef enum logic [1:0] {
        ENC_IDLE,
        ENC_ARM,
        ENC_MARK,
        ENC_SPACE
    } enc_state_e;

    typedef enum logic [1:0] {
        DEC_IDLE,
        DEC_QUAL,
        DEC_LOW
    } dec_state_e;

endpackage

// File: rtl/sir_enc.sv
module sir_enc
    import sir_pkg::*;
#(
    parameter int BIT_TICKS      = 16,
    parameter int PULSE_TICKS    = 3,
    parameter int LP_PULSE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic lowpwr,
    input  logic tick16,
    input  logic lp_tick,
    input  logic tx_bit,
    output logic pulse
);

    localparam int PH_W = $clog2(BIT_TICKS);
    localparam int MAXP = (PULSE_TICKS > LP_PULSE_TICKS) ? PULSE_TICKS : LP_PULSE_TICKS;
    localparam int PC_W = $clog2(MAXP + 1);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(BIT_TICKS - 1);
    localparam logic [PC_W-1:0] NRM_LAST = PC_W'(PULSE_TICKS - 1);
    localparam logic [PC_W-1:0] LP_LAST  = PC_W'(LP_PULSE_TICKS - 1);

    enc_state_e      state, nxt;
    logic [PH_W-1:0] bit_ph;
    logic [PC_W-1:0] pc;
    logic            lp_q;
    logic            want, bit_end, pw_tick, pw_last, bit_start;

    // next state
    always_comb begin
        nxt       = state;
        bit_start = 1'b0;
        want      = active && !tx_bit;
        bit_end   = tick16 && (bit_ph == PH_LAST);
        pw_tick   = lp_q ? lp_tick : tick16;
        pw_last   = (pc == (lp_q ? LP_LAST : NRM_LAST));
        unique case (state)
            ENC_IDLE: begin
                if (want && tick16) begin
                    bit_start = 1'b1;
                    nxt       = lowpwr ? ENC_ARM : ENC_MARK;
                end
            end
            ENC_ARM: begin
                if (lp_tick) nxt = ENC_MARK;
            end
            ENC_MARK: begin
                if (pw_tick && pw_last) nxt = ENC_SPACE;
            end
            ENC_SPACE: begin
                nxt = ENC_SPACE;
            end
            default: nxt = ENC_IDLE;
        endcase
        if (state != ENC_IDLE && bit_end) begin
            if (want) begin
                bit_start = 1'b1;
                nxt       = lowpwr ? ENC_ARM : ENC_MARK;
            end else begin
                nxt = ENC_IDLE;
            end
        end
        if (!active) begin
            nxt       = ENC_IDLE;
            bit_start = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ENC_IDLE;
        else        state <= nxt;
    end

    // bit phase and pulse length counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_ph <= '0;
            pc     <= '0;
            lp_q   <= 1'b0;
        end else begin
            if (bit_start) begin
                bit_ph <= '0;
                lp_q   <= lowpwr;
            end else if (tick16 && state != ENC_IDLE) begin
                bit_ph <= bit_ph + 1'b1;
            end
            if (bit_start || (state == ENC_ARM && lp_tick))
                pc <= '0;
            else if (state == ENC_MARK && pw_tick)
                pc <= pc + 1'b1;
        end
    end

    // outputs
    always_comb begin
        pulse = (state == ENC_MARK);
    end

endmodule

// File: rtl/sir_dec.sv
module sir_dec
    import sir_pkg::*;
#(
    parameter int BIT_TICKS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick16,
    input  logic pulse_n,
    output logic rx_bit
);

    localparam int CW = $clog2(BIT_TICKS);
    localparam logic [CW-1:0] C_LAST = CW'(BIT_TICKS - 1);

    dec_state_e             state, nxt;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   seen, seen_d, pend, reload, enter;
    logic [CW-1:0]          cnt;

    assign seen = !sync_q[SYNC_STAGES-1];

    // input synchroniser, idle level forced while SIR is inactive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], (active ? pulse_n : 1'b1)};
    end

    // next state
    always_comb begin
        nxt    = state;
        enter  = 1'b0;
        reload = 1'b0;
        unique case (state)
            DEC_IDLE: begin
                if (seen) begin
                    if (tick16) begin
                        nxt   = DEC_LOW;
                        enter = 1'b1;
                    end else begin
                        nxt = DEC_QUAL;
                    end
                end
            end
            DEC_QUAL: begin
                if (!seen) begin
                    nxt = DEC_IDLE;
                end else if (tick16) begin
                    nxt   = DEC_LOW;
                    enter = 1'b1;
                end
            end
            DEC_LOW: begin
                if (tick16 && cnt == C_LAST) begin
                    if (pend || seen) begin
                        reload = 1'b1;
                    end else begin
                        nxt = DEC_IDLE;
                    end
                end
            end
            default: nxt = DEC_IDLE;
        endcase
        if (!active) begin
            nxt    = DEC_IDLE;
            enter  = 1'b0;
            reload = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DEC_IDLE;
        else        state <= nxt;
    end

    // stretch counter and pending-pulse flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            pend   <= 1'b0;
            seen_d <= 1'b0;
        end else begin
            seen_d <= seen;
            if (enter || reload) begin
                cnt  <= '0;
                pend <= 1'b0;
            end else if (state == DEC_LOW) begin
                if (tick16) cnt <= cnt + 1'b1;
                if (seen && !seen_d) pend <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        rx_bit = (state != DEC_LOW);
    end

endmodule

// File: rtl/sir_route.sv
module sir_route (
    input  logic uart_en,
    input  logic sir_en,
    input  logic loop_en,
    input  logic sir_test,
    input  logic uart_txd_in,
    input  logic rxd_in,
    input  logic sir_rx_n,
    input  logic enc_pulse,
    input  logic dec_rx,
    output logic active,
    output logic dec_in_n,
    output logic txd,
    output logic uart_rxd
);

    always_comb begin
        active   = uart_en && sir_en;
        txd      = active ? 1'b1 : uart_txd_in;
        dec_in_n = (loop_en && sir_test) ? !enc_pulse : sir_rx_n;
        if (active)
            uart_rxd = dec_rx;
        else if (loop_en && !sir_test)
            uart_rxd = uart_txd_in;
        else
            uart_rxd = rxd_in;
    end

endmodule

// File: rtl/sir_codec.sv
module sir_codec #(
    parameter int BIT_TICKS      = 16,
    parameter int PULSE_TICKS    = 3,
    parameter int LP_PULSE_TICKS = 3,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic lp_tick,
    input  logic uart_txd_in,
    input  logic rxd_in,
    input  logic sir_rx_n,
    input  logic cfg_uart_en,
    input  logic cfg_sir_en,
    input  logic cfg_lowpwr,
    input  logic cfg_loop,
    input  logic cfg_sir_test,
    output logic sir_tx,
    output logic uart_rxd,
    output logic txd
);

    logic active, dec_in_n, dec_rx, enc_pulse;

    sir_route u_route (
        .uart_en     (cfg_uart_en),
        .sir_en      (cfg_sir_en),
        .loop_en     (cfg_loop),
        .sir_test    (cfg_sir_test),
        .uart_txd_in (uart_txd_in),
        .rxd_in      (rxd_in),
        .sir_rx_n    (sir_rx_n),
        .enc_pulse   (enc_pulse),
        .dec_rx      (dec_rx),
        .active      (active),
        .dec_in_n    (dec_in_n),
        .txd         (txd),
        .uart_rxd    (uart_rxd)
    );

    sir_enc #(
        .BIT_TICKS      (BIT_TICKS),
        .PULSE_TICKS    (PULSE_TICKS),
        .LP_PULSE_TICKS (LP_PULSE_TICKS)
    ) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .lowpwr  (cfg_lowpwr),
        .tick16  (tick16),
        .lp_tick (lp_tick),
        .tx_bit  (uart_txd_in),
        .pulse   (enc_pulse)
    );

    sir_dec #(
        .BIT_TICKS   (BIT_TICKS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .tick16  (tick16),
        .pulse_n (dec_in_n),
        .rx_bit  (dec_rx)
    );

    assign sir_tx = enc_pulse;

endmodule

// File: rtl/sir_codec_chk.sv
module sir_codec_chk (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic lp_tick,
    input logic uart_txd_in,
    input logic rxd_in,
    input logic cfg_uart_en,
    input logic cfg_sir_en,
    input logic cfg_loop,
    input logic cfg_sir_test,
    input logic sir_tx,
    input logic uart_rxd,
    input logic txd
);

    logic act;
    assign act = cfg_uart_en && cfg_sir_en;

    AST_OFF_NO_LIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> !sir_tx); // R4

    AST_PLAIN_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !cfg_loop) |-> (uart_rxd == rxd_in)); // R4

    AST_TXD_MARKING: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> txd); // R5

    AST_UART_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_uart_en |-> (txd == uart_txd_in)); // R6

    AST_PLAIN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && cfg_loop && !cfg_sir_test) |-> (uart_rxd == uart_txd_in)); // R8

    AST_PULSE_START_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sir_tx) |-> $past(tick16 || lp_tick)); // R1

    AST_PULSE_END_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sir_tx) |-> $past(tick16 || lp_tick || !act)); // R2

    AST_RXD_FALL_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $past(act) && $fell(uart_rxd)) |-> $past(tick16)); // R9

endmodule

bind sir_codec sir_codec_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick16       (tick16),
    .lp_tick      (lp_tick),
    .uart_txd_in  (uart_txd_in),
    .rxd_in       (rxd_in),
    .cfg_uart_en  (cfg_uart_en),
    .cfg_sir_en   (cfg_sir_en),
    .cfg_loop     (cfg_loop),
    .cfg_sir_test (cfg_sir_test),
    .sir_tx       (sir_tx),
    .uart_rxd     (uart_rxd),
    .txd          (txd)
);

// File: tb/tb_sir_codec.sv
module tb_sir_codec;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic tick16 = 1'b0, lp_tick = 1'b0;
    logic uart_txd_in = 1'b1, rxd_in = 1'b0, sir_rx_n = 1'b1;
    logic cfg_uart_en = 1'b0, cfg_sir_en = 1'b0, cfg_lowpwr = 1'b0;
    logic cfg_loop = 1'b0, cfg_sir_test = 1'b0;
    logic sir_tx, uart_rxd, txd;

    int tick_div = 4, lp_div = 7, tcnt = 0, lcnt = 0;
    int n_chk = 0, n_bad = 0;
    int exp_w = 12, tx_run = 0, n_pulse = 0, n_badw = 0;
    int rx_run = 0, n_rxlow = 0, last_rxlow = 0;

    sir_codec dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .lp_tick(lp_tick),
        .uart_txd_in(uart_txd_in), .rxd_in(rxd_in), .sir_rx_n(sir_rx_n),
        .cfg_uart_en(cfg_uart_en), .cfg_sir_en(cfg_sir_en), .cfg_lowpwr(cfg_lowpwr),
        .cfg_loop(cfg_loop), .cfg_sir_test(cfg_sir_test),
        .sir_tx(sir_tx), .uart_rxd(uart_rxd), .txd(txd)
    );

    // tick enables, changed away from the active edge
    always @(negedge clk) begin
        if (tcnt >= tick_div - 1) begin tcnt <= 0; tick16 <= 1'b1; end
        else begin tcnt <= tcnt + 1; tick16 <= 1'b0; end
        if (lcnt >= lp_div - 1) begin lcnt <= 0; lp_tick <= 1'b1; end
        else begin lcnt <= lcnt + 1; lp_tick <= 1'b0; end
    end

    // pulse and low-run monitors
    always @(negedge clk) begin
        if (!rst_n) begin
            tx_run = 0;
            rx_run = 0;
        end else begin
            if (sir_tx === 1'b1) tx_run++;
            else if (tx_run > 0) begin
                n_pulse++;
                if (tx_run != exp_w) n_badw++;
                tx_run = 0;
            end
            if (uart_rxd === 1'b0) rx_run++;
            else if (rx_run > 0) begin
                n_rxlow++;
                last_rxlow = rx_run;
                rx_run = 0;
            end
        end
    end

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int zeros(input logic [15:0] p, input int nb);
        int z = 0;
        for (int i = 0; i < nb; i++) if (!p[i]) z++;
        return z;
    endfunction

    // mode 0: uart_rxd follows rxd_in, mode 1: follows uart_txd_in
    task automatic plain_random(input string tag, input int mode);
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            uart_txd_in = 1'($urandom_range(0, 1));
            rxd_in      = 1'($urandom_range(0, 1));
            sir_rx_n    = 1'($urandom_range(0, 1));
            #2;
            check({tag, " txd follows line"}, txd, uart_txd_in);
            check({tag, " uart_rxd source"}, uart_rxd, (mode == 1) ? uart_txd_in : rxd_in);
            check({tag, " sir_tx dark"}, sir_tx, 0);
        end
        @(negedge clk);
        uart_txd_in = 1'b1;
        sir_rx_n    = 1'b1;
    endtask

    task automatic send_frame(input logic [15:0] pat, input int nb,
                              input bit chk_dec, input string tag);
        int p0, w0;
        p0 = n_pulse;
        w0 = n_badw;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            uart_txd_in = pat[i];
            repeat (10 * tick_div - 1) @(negedge clk);
            #1;
            if (chk_dec) check({tag, " R7 looped bit"}, uart_rxd, pat[i]);
            check({tag, " R5 txd marking"}, txd, 1);
            repeat (6 * tick_div) @(negedge clk);
        end
        @(negedge clk);
        uart_txd_in = 1'b1;
        repeat (32 * tick_div) @(negedge clk);
        check({tag, " pulse count"}, n_pulse - p0, zeros(pat, nb));
        check({tag, " pulse width errors"}, n_badw - w0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all-R actual=timeout expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] pat;
        int r0;
        void'($urandom(32'd20250));

        // R11 reset state
        repeat (5) @(negedge clk);
        #1;
        check("R11 sir_tx in reset", sir_tx, 0);
        check("R11 txd in reset", txd, 1);
        check("R11 uart_rxd in reset", uart_rxd, 0);
        @(negedge clk);
        rst_n = 1'b1;
        cfg_uart_en = 1'b1;
        cfg_sir_en  = 1'b1;
        repeat (10) @(negedge clk);
        #1;
        check("R11 sir_tx after reset", sir_tx, 0);
        check("R11 uart_rxd idle", uart_rxd, 1);

        // R4 SIR disabled
        cfg_sir_en = 1'b0;
        plain_random("R4", 0);
        // R6 UART disabled, SIR enable set
        cfg_uart_en = 1'b0;
        cfg_sir_en  = 1'b1;
        plain_random("R6", 0);
        // R8 plain loopback
        cfg_uart_en = 1'b1;
        cfg_sir_en  = 1'b0;
        cfg_loop    = 1'b1;
        plain_random("R8", 1);

        // R5 SIR active, plain receive ignored
        cfg_loop   = 1'b0;
        cfg_sir_en = 1'b1;
        repeat (20) @(negedge clk);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            rxd_in = 1'($urandom_range(0, 1));
            #2;
            check("R5 txd held high", txd, 1);
            check("R5 rxd_in ignored", uart_rxd, 1);
        end

        // R1 R3 R7 normal pulses, SIR test loopback, external input held low
        rxd_in       = 1'b0;
        cfg_loop     = 1'b1;
        cfg_sir_test = 1'b1;
        sir_rx_n     = 1'b0;
        tick_div     = 4;
        exp_w        = 12;
        repeat (64) @(negedge clk);
        send_frame(16'h0000, 10, 1'b1, "R1 zeros");
        send_frame(16'hFFFF, 10, 1'b1, "R3 ones");
        send_frame(16'h0155, 10, 1'b1, "R1 alternating");
        for (int k = 0; k < 3; k++) begin
            pat = 16'($urandom());
            send_frame(pat, 10, 1'b1, "R1 random");
        end
        // R1 at half the bit rate
        tick_div = 8;
        exp_w    = 24;
        repeat (64) @(negedge clk);
        pat = 16'($urandom());
        send_frame(pat, 10, 1'b1, "R1 slow rate");

        // R2 low-power width set by reference tick only
        cfg_loop     = 1'b0;
        cfg_sir_test = 1'b0;
        sir_rx_n     = 1'b1;
        cfg_lowpwr   = 1'b1;
        tick_div     = 4;
        lp_div       = 7;
        exp_w        = 21;
        repeat (64) @(negedge clk);
        pat = 16'($urandom());
        send_frame(pat, 10, 1'b0, "R2 lp fast rate");
        tick_div = 8;
        repeat (64) @(negedge clk);
        send_frame(16'h0292, 10, 1'b0, "R2 lp slow rate");
        lp_div = 3;
        exp_w  = 9;
        repeat (64) @(negedge clk);
        send_frame(16'h0000, 8, 1'b0, "R2 lp short ref");

        // R10 glitch rejection, R9 stretch
        cfg_lowpwr = 1'b0;
        tick_div   = 8;
        repeat (300) @(negedge clk);
        r0 = n_rxlow;
        do begin
            @(negedge clk);
            #1;
        end while (tick16 !== 1'b1);
        @(negedge clk);
        sir_rx_n = 1'b0;
        repeat (3) @(negedge clk);
        sir_rx_n = 1'b1;
        repeat (160) @(negedge clk);
        #1;
        check("R10 glitch produced no low run", n_rxlow - r0, 0);
        check("R10 uart_rxd stays high", uart_rxd, 1);

        @(negedge clk);
        sir_rx_n = 1'b0;
        repeat (16) @(negedge clk);
        sir_rx_n = 1'b1;
        repeat (80) @(negedge clk);
        #1;
        check("R9 stretched low mid-bit", uart_rxd, 0);
        repeat (100) @(negedge clk);
        check("R9 one low run", n_rxlow - r0, 1);
        check("R9 low run length", last_rxlow, 128);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule